// File: doc/BRIEF.md
# Dual-Bank RAM Window Mapper

This block holds the mapping of a 256 KB onboard RAM, built as two 128 KB banks, into the 1 MB memory space of an 8-bit PC-style bus. Software sets the map with a single I/O write to an eight-port range starting at 0A0h. Only the upper port-address bits are compared, so all eight ports reach the same register. The register cannot be read back.

For every memory address, the block reports which bank, if any, the address falls in, and where inside that bank it lands. Both answers come from plain logic in the same cycle. A 3-bit placement code in the register sets the upper bank's start. A size bit decides whether the lower bank sits directly below the upper bank or is switched off. Placement codes above 4 take both banks out of conventional memory. The DRAM timing, refresh, video fetch and data path lie outside the block.

Top module: `bank_map_ctrl`

## Requirements
- R1: An I/O write (iow=1, aen=0) to any port from 0A0h to 0A7h loads the control byte at the next rising clock edge. Ports 09Fh and 0A8h leave it unchanged. The compare uses addr[15:3] only.
- R2: While aen is 1, an iow pulse in the port range does not change the control byte.
- R3: The placement code is control bits [3:1]. For codes 0 to 4, the upper bank (sel_hi) covers code×20000h up to code×20000h+1FFFFh.
- R4: When control bit 4 is 1 and the code is 1 to 4, the lower bank (sel_lo) covers the 128 KB just below the upper bank. With code 0 the lower bank is never selected.
- R5: When control bit 4 is 0, sel_lo is never asserted, and the upper bank stays where the code puts it, leaving a hole below it.
- R6: Codes 5, 6 and 7 all behave the same: sel_hi, sel_lo and hit stay 0 for every address.
- R7: After reset the control byte is 98h. The upper bank is then at 80000h–9FFFFh and the lower bank at 60000h–7FFFFh.
- R8: Bytes 94h and 96h are accepted as written. For 94h the banks are at 40000h (upper) and 20000h (lower). For 96h they are at 60000h (upper) and 40000h (lower).
- R9: Control bits 0, 5, 6 and 7 have no effect on any output.
- R10: sel_hi and sel_lo are never both 1, and hit equals their OR. offset is the address minus the base of the selected bank, which is addr[16:0]. offset is 0 when hit is 0.
- R11: The outputs follow addr in the same cycle. A new control byte takes effect in the cycle after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 20 | Bus address; the I/O port is taken from bits [15:0] |
| wdata | input | 8 | Data bus, sampled on a decoded I/O write |
| iow | input | 1 | I/O write strobe, active high |
| aen | input | 1 | DMA address enable; when 1, I/O decoding is blocked |
| sel_hi | output | 1 | Address falls in the upper bank |
| sel_lo | output | 1 | Address falls in the lower bank |
| hit | output | 1 | Address falls in either bank |
| offset | output | 17 | Byte offset inside the selected bank |

## Verification
The bench builds the block with its default parameters: a 20-bit address, 128 KB banks, port base 0A0h and an eight-port span. With these values every 128 KB window of the 1 MB space can be swept at its first byte, at a middle byte and at its last byte.

Those sweeps are repeated after reset and after each control byte of interest. These include the hole configuration, all three reserved codes, the overlapping placements, bytes that set only the ignored bits, and code 0 with the size bit set. Writes are also sent to ports at the edges of the decoded range and with aen high, so that every decode boundary is reached.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

  // Decoded view of the control byte
  typedef struct packed {
    logic [2:0] code;   // placement of the upper bank
    logic       full;   // 1: lower bank enabled
  } map_cfg_t;

  // Placement codes above this value take the banks out of conventional memory
  localparam int unsigned CODE_MAX = 4;

  // Bits 3..1 carry the code, bit 4 the size; the remaining bits are ignored
  function automatic map_cfg_t cfg_from_byte(input logic [7:0] b);
    map_cfg_t c;
    c.code = b[3:1];
    c.full = b[4];
    return c;
  endfunction

  function automatic logic code_mapped(input logic [2:0] code);
    return 32'(code) <= CODE_MAX;
  endfunction

endpackage

// File: rtl/bmap_port_dec.sv
module bmap_port_dec #(
  parameter int IO_W      = 16,
  parameter int SPAN_W    = 3,
  parameter int PORT_BASE = 16'h00A0
) (
  input  logic [IO_W-1:SPAN_W] port_hi,
  input  logic                 iow,
  input  logic                 aen,
  output logic                 wr_en
);
  localparam int HI_W = IO_W - SPAN_W;
  localparam logic [HI_W-1:0] MATCH = HI_W'(PORT_BASE >> SPAN_W);

  logic port_match;
  assign port_match = (port_hi == MATCH);
  assign wr_en      = port_match & iow & ~aen;
endmodule

// File: rtl/bmap_ctl_reg.sv
module bmap_ctl_reg #(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] RESET_VAL = 8'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctl <= DATA_W'(RESET_VAL);
    else if (wr_en) ctl <= wdata;
  end

  // R1: the byte changes only through a decoded write
  assert_hold_without_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl));

  // R1: a decoded write lands in the register
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctl == $past(wdata));
endmodule

// File: rtl/bmap_window.sv
module bmap_window
  import bmap_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BANK_W   = 17,
  parameter bit IS_LOWER = 1'b0
) (
  input  logic [ADDR_W-1:BANK_W] win_idx,
  input  map_cfg_t               cfg,
  output logic                   match
);
  localparam int IDX_W = ADDR_W - BANK_W;

  logic [IDX_W-1:0] target;
  logic             enabled;

  generate
    if (IS_LOWER) begin : g_lower
      assign target  = IDX_W'(cfg.code) - IDX_W'(1);
      assign enabled = code_mapped(cfg.code) & cfg.full & (cfg.code != 3'd0);
    end else begin : g_upper
      assign target  = IDX_W'(cfg.code);
      assign enabled = code_mapped(cfg.code);
    end
  endgenerate

  assign match = enabled & (win_idx == target);
endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bmap_pkg::*;
#(
  parameter int         ADDR_W    = 20,
  parameter int         BANK_W    = 17,
  parameter int         IO_W      = 16,
  parameter int         SPAN_W    = 3,
  parameter int         PORT_BASE = 16'h00A0,
  parameter logic [7:0] RESET_VAL = 8'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              iow,
  input  logic              aen,
  output logic              sel_hi,
  output logic              sel_lo,
  output logic              hit,
  output logic [BANK_W-1:0] offset
);
  localparam int NBANK = 2;
  localparam int IDX_W = ADDR_W - BANK_W;

  logic           wr_en;
  logic [7:0]     ctl;
  map_cfg_t       cfg;
  logic [NBANK-1:0] match;

  bmap_port_dec #(.IO_W(IO_W), .SPAN_W(SPAN_W), .PORT_BASE(PORT_BASE)) u_dec (
    .port_hi (addr[IO_W-1:SPAN_W]),
    .iow     (iow),
    .aen     (aen),
    .wr_en   (wr_en)
  );

  bmap_ctl_reg #(.DATA_W(8), .RESET_VAL(RESET_VAL)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (wdata),
    .ctl   (ctl)
  );

  assign cfg = cfg_from_byte(ctl);

  // index 0: upper bank, index 1: lower bank
  for (genvar g = 0; g < NBANK; g++) begin : g_win
    bmap_window #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .IS_LOWER(g == 1)) u_win (
      .win_idx (addr[ADDR_W-1:BANK_W]),
      .cfg     (cfg),
      .match   (match[g])
    );
  end

  // Base of the bank that hit, subtracted from the address
  function automatic logic [BANK_W-1:0] bank_offset(input logic [ADDR_W-1:0] a,
                                                    input logic [IDX_W-1:0]  base_idx);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] diff;
    base = {base_idx, {BANK_W{1'b0}}};
    diff = a - base;
    return diff[BANK_W-1:0];
  endfunction

  logic [IDX_W-1:0] hit_idx;
  assign hit_idx = match[1] ? IDX_W'(cfg.code) - IDX_W'(1) : IDX_W'(cfg.code);

  assign sel_hi = match[0];
  assign sel_lo = match[1];
  assign hit    = |match;
  assign offset = hit ? bank_offset(addr, hit_idx) : '0;

  // R2: the bus owner other than the CPU can never reach the register
  assert_aen_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> !wr_en);

  // R10: the two windows never claim the same address
  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R5: with the size bit cleared the lower window stays silent
  assert_lower_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[4] |-> !sel_lo);

  // R6: reserved codes unmap both banks
  assert_reserved_nohit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[3:1] > 3'd4) |-> !hit);

  // R10: the offset is zero whenever nothing is hit
  assert_offset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> offset == '0);
endmodule

// File: tb/sim_bank_map_ctrl.sv
`timescale 1ns/1ps
module sim_bank_map_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        iow = 1'b0;
  logic        aen = 1'b0;
  logic        sel_hi, sel_lo, hit;
  logic [16:0] offset;

  int errors = 0;
  int checks = 0;
  int model = 'h98;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_map_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .iow(iow), .aen(aen),
    .sel_hi(sel_hi), .sel_lo(sel_lo), .hit(hit), .offset(offset)
  );

  // Reference: ranges computed as byte arithmetic on the model byte
  task automatic check_now(input string tag);
    int code, ub, lb, a, eoff;
    bit esh, esl, eh;
    a = int'(addr);
    code = (model >> 1) & 7;
    ub = code * 131072;
    lb = ub - 131072;
    esh = (code <= 4) && a >= ub && a < ub + 131072;
    esl = (code <= 4) && ((model & 16) != 0) && code >= 1 && a >= lb && a < ub;
    eh = esh || esl;
    eoff = esh ? a - ub : (esl ? a - lb : 0);
    checks++;
    if (sel_hi !== esh || sel_lo !== esl || hit !== eh || int'(offset) !== eoff) begin
      errors++;
      $display("FAIL %s addr=%05h ctl=%02h actual hi=%b lo=%b hit=%b off=%05h expected hi=%b lo=%b hit=%b off=%05h",
               tag, addr, model, sel_hi, sel_lo, hit, offset, esh, esl, eh, eoff);
    end
  endtask

  task automatic cycle(input int a, input int d, input bit w, input bit e, input string tag);
    @(negedge clk);
    addr = 20'(a); wdata = 8'(d); iow = w; aen = e;
    #1 check_now(tag);
    @(posedge clk);
    if (w && !e && a >= 'hA0 && a <= 'hA7) model = d;
  endtask

  task automatic sweep(input string tag);
    for (int w = 0; w < 8; w++) begin
      cycle(w * 131072, 0, 0, 0, tag);
      cycle(w * 131072 + 'h0ABCD, 0, 0, 0, tag);
      cycle(w * 131072 + 'h1FFFF, 0, 0, 0, tag);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    sweep("R7 reset map");
    cycle('hA0, 'h88, 1, 0, "R1 write A0");
    sweep("R5 hole below upper");
    cycle('hA3, 'h98, 1, 1, "R2 aen write");
    sweep("R2 aen blocked");
    cycle('hA8, 'h98, 1, 0, "R1 port A8");
    cycle('h9F, 'h98, 1, 0, "R1 port 9F");
    sweep("R1 out-of-range ignored");
    cycle('hA7, 'h98, 1, 0, "R1 write A7");
    cycle('h60000, 0, 0, 0, "R11 next cycle");
    for (int c = 0; c < 5; c++) begin
      cycle('hA4, 'h10 | (c << 1), 1, 0, "R3 code write");
      sweep("R3 R4 placement");
    end
    for (int c = 5; c < 8; c++) begin
      cycle('hA2, 'h10 | (c << 1), 1, 0, "R6 reserved write");
      sweep("R6 reserved code");
    end
    cycle('hA1, 'h94, 1, 0, "R8 write 94");
    sweep("R8 overlap 94");
    cycle('hA6, 'h96, 1, 0, "R8 write 96");
    sweep("R8 overlap 96");
    cycle('hA5, 'hE9, 1, 0, "R9 write E9");
    sweep("R9 spare bits set");
    cycle('hA5, 'h7F, 1, 0, "R9 write 7F");
    sweep("R9 R10 spare bits code 7");
    cycle('hA0, 'h07, 1, 0, "R9 write 07");
    sweep("R10 offset check");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule